// File: doc/BRIEF.md
# SPI Register Target with Frame Validation

This block is a serial peripheral interface target that gives an external host access to a small bank of 8-bit registers. The host selects the block with an active-low select line, clocks 16-bit words in on the data input, and receives a 16-bit response on the data output during the same frame. Each incoming word carries a read/write flag, a 4-bit register address and a data byte. Register address 0 is a read-only status register. Addresses 1 to `NUM_CFG` are read/write configuration registers whose contents drive the `cfg_o` bus.

The serial pins are brought into the system clock domain through short synchronisers. Edges of the serial clock are detected there, so the system clock must run several times faster than the serial clock. A frame takes effect only when chip select returns high, and only if it is well formed. A well-formed frame has exactly 16 clock cycles and a serial clock that is low at both edges of chip select. A frame that breaks these rules leaves every register as it was and sets a sticky frame-error flag. A successful read of the status register clears that flag.

Top module: `spi_reg_target`

## Requirements
- R1: `spi_sdo_en` is low whenever `spi_cs_n` is high, and high whenever it is low. After deselection, `spi_sdo` settles low within a few system clocks.
- R2: The word is shifted MSB first and sampled on falling serial clock edges. Bit 15 = 1 requests a read and 0 a write. Bits 14:11 are the address, bits 10:8 are reserved and ignored, and bits 7:0 are the write data.
- R3: A valid write to address k (1 to NUM_CFG) stores bits 7:0 in `cfg_o[8k-1:8k-8]`. `cfg_o` changes only after chip select rises.
- R4: In each frame the output shifts out 16 bits MSB first, changing after rising serial clock edges. Bit 15 is the frame-error flag as it was when the frame started. Bits 14:8 are zero. Bits 7:0 are the addressed register's value before the frame, so a write returns the old value.
- R5: Address 0 reads as {`stat_i[6:0]` in bits 7:1, frame-error flag in bit 0}, and writes to it are ignored. Addresses above NUM_CFG read as zero, and writes to them are ignored.
- R6: A frame with any count of falling serial clock edges other than 16 changes no register and sets `frame_err_o`.
- R7: A frame where the serial clock is high when chip select falls, or when it rises, changes no register and sets `frame_err_o`.
- R8: `frame_err_o` stays set until a valid read of address 0 completes. Writes to address 0 and reads of other addresses leave it set.
- R9: Serial clock and data activity while `spi_cs_n` is high has no effect on registers, flag or outputs.
- R10: After reset, all configuration registers are zero, `frame_err_o` is low and `spi_sdo` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| spi_cs_n | input | 1 | Active-low chip select from the host |
| spi_sclk | input | 1 | Serial clock from the host, idle low |
| spi_sdi | input | 1 | Serial data from the host |
| spi_sdo | output | 1 | Serial data to the host |
| spi_sdo_en | output | 1 | Pad drive enable for spi_sdo; pad floats when low |
| stat_i | input | 7 | Status bits reported in bits 7:1 of register 0 |
| cfg_o | output | NUM_CFG*8 | Configuration register contents, register k in byte k-1 |
| frame_err_o | output | 1 | Sticky frame-error flag |

## Verification
The checker module checks several things on every cycle. Configuration registers move only in the cycle after an accepted frame. The error flag rises only after a rejected frame and holds until a clearing read. The edge counters stay frozen while the target is deselected. The data output is quiet after deselection. The bench's scenarios are needed for the rest: whether each address decodes to the right byte, the bit order and content of the response word, the old value returned by a write, and the rejection of every frame length from 0 to 20. Malformed select timing and idle bus activity are also shown only by the bench's scenarios.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam int FRAME_BITS = 16;
  localparam int ADDR_W     = 4;
  localparam int DATA_W     = 8;
  localparam int RSVD_W     = FRAME_BITS - 1 - ADDR_W - DATA_W;
  localparam logic [ADDR_W-1:0] STATUS_ADDR = '0;

  typedef struct packed {
    logic              rd;
    logic [ADDR_W-1:0] addr;
    logic [RSVD_W-1:0] rsvd;
    logic [DATA_W-1:0] data;
  } spi_word_t;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_i,
  input  logic sclk_i,
  input  logic sdi_i,
  output logic cs_n_o,
  output logic sclk_o,
  output logic sdi_o,
  output logic cs_fall_o,
  output logic cs_rise_o,
  output logic sclk_fall_o,
  output logic sclk_rise_o
);
  localparam int LANES = 3;
  localparam logic [LANES-1:0] IDLE_VAL = 3'b100;

  logic [LANES-1:0]  raw;
  logic [LANES-1:0]  synced;
  logic [STAGES-1:0] chain_q [LANES];
  logic [1:0]        prev_q;

  assign raw = {cs_n_i, sclk_i, sdi_i};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[g] <= {STAGES{IDLE_VAL[g]}};
      else        chain_q[g] <= {chain_q[g][STAGES-2:0], raw[g]};
    end
    assign synced[g] = chain_q[g][STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 2'b10;
    else        prev_q <= synced[2:1];
  end

  assign cs_n_o      = synced[2];
  assign sclk_o      = synced[1];
  assign sdi_o       = synced[0];
  assign cs_fall_o   = prev_q[1] & ~synced[2];
  assign cs_rise_o   = ~prev_q[1] & synced[2];
  assign sclk_fall_o = prev_q[0] & ~synced[1];
  assign sclk_rise_o = ~prev_q[0] & synced[1];
endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
  import spi_reg_pkg::*;
#(
  parameter int CNT_W = $clog2(FRAME_BITS + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_s,
  input  logic              sclk_s,
  input  logic              sdi_s,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              sclk_fall,
  input  logic              sclk_rise,
  input  logic              err_flag_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              sdo_o,
  output logic              commit_ok_o,
  output logic              commit_bad_o,
  output logic              commit_rd_o,
  output logic [ADDR_W-1:0] commit_addr_o,
  output logic [DATA_W-1:0] commit_data_o,
  output logic [CNT_W-1:0]  fall_cnt_o
);
  localparam int IDX_W = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_FULL  = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_SAT   = CNT_W'(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] ADDR_DONE = CNT_W'(ADDR_W);
  localparam logic [IDX_W-1:0] TOP_IDX   = IDX_W'(FRAME_BITS - 1);

  logic [CNT_W-1:0]      fall_q, fall_d, rise_q, rise_d;
  logic [FRAME_BITS-1:0] rx_q, rx_d;
  logic                  start_bad_q, start_bad_d;
  logic                  err_snap_q, err_snap_d;
  logic [DATA_W-1:0]     rd_byte_q, rd_byte_d;
  logic                  sdo_q, sdo_d;
  logic                  addr_stb_q, addr_stb_d;
  logic [FRAME_BITS-1:0] tx_word;
  logic                  frame_ok;
  spi_word_t             rx_word;

  assign tx_word = {err_snap_q, {(FRAME_BITS-DATA_W-1){1'b0}}, rd_byte_q};

  always_comb begin
    fall_d      = fall_q;
    rise_d      = rise_q;
    rx_d        = rx_q;
    start_bad_d = start_bad_q;
    err_snap_d  = err_snap_q;
    rd_byte_d   = rd_byte_q;
    sdo_d       = sdo_q;
    addr_stb_d  = 1'b0;
    if (cs_n_s) sdo_d = 1'b0;
    if (cs_fall) begin
      fall_d      = '0;
      rise_d      = '0;
      rx_d        = '0;
      start_bad_d = sclk_s;
      err_snap_d  = err_flag_i;
      rd_byte_d   = '0;
      sdo_d       = 1'b0;
    end else if (!cs_n_s) begin
      if (sclk_fall) begin
        rx_d       = {rx_q[FRAME_BITS-2:0], sdi_s};
        addr_stb_d = (fall_q == ADDR_DONE);
        if (fall_q != CNT_SAT) fall_d = fall_q + CNT_W'(1);
      end
      if (sclk_rise) begin
        if (rise_q < CNT_FULL) sdo_d = tx_word[TOP_IDX - rise_q[IDX_W-1:0]];
        else                   sdo_d = 1'b0;
        if (rise_q != CNT_SAT) rise_d = rise_q + CNT_W'(1);
      end
      if (addr_stb_q) rd_byte_d = rd_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fall_q      <= '0;
      rise_q      <= '0;
      rx_q        <= '0;
      start_bad_q <= 1'b0;
      err_snap_q  <= 1'b0;
      rd_byte_q   <= '0;
      sdo_q       <= 1'b0;
      addr_stb_q  <= 1'b0;
    end else begin
      fall_q      <= fall_d;
      rise_q      <= rise_d;
      rx_q        <= rx_d;
      start_bad_q <= start_bad_d;
      err_snap_q  <= err_snap_d;
      rd_byte_q   <= rd_byte_d;
      sdo_q       <= sdo_d;
      addr_stb_q  <= addr_stb_d;
    end
  end

  assign frame_ok      = (fall_q == CNT_FULL) && (rise_q == CNT_FULL) && !start_bad_q && !sclk_s;
  assign commit_ok_o   = cs_rise & frame_ok;
  assign commit_bad_o  = cs_rise & ~frame_ok;
  assign rx_word       = spi_word_t'(rx_q);
  assign commit_rd_o   = rx_word.rd;
  assign commit_addr_o = rx_word.addr;
  assign commit_data_o = rx_word.data;
  assign rd_addr_o     = rx_q[ADDR_W-1:0];
  assign sdo_o         = sdo_q;
  assign fall_cnt_o    = fall_q;
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
  import spi_reg_pkg::*;
#(
  parameter int NUM_CFG = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      commit_ok,
  input  logic                      commit_bad,
  input  logic                      commit_rd,
  input  logic [ADDR_W-1:0]         commit_addr,
  input  logic [DATA_W-1:0]         commit_data,
  input  logic [ADDR_W-1:0]         rd_addr,
  input  logic [DATA_W-2:0]         stat_i,
  output logic [DATA_W-1:0]         rd_data,
  output logic [NUM_CFG*DATA_W-1:0] cfg_o,
  output logic                      err_o
);
  logic [DATA_W-1:0] cfg_q [NUM_CFG];
  logic              err_q, err_d, err_en;
  logic              err_clr;

  for (genvar i = 0; i < NUM_CFG; i++) begin : g_cfg
    logic wr_en;
    assign wr_en = commit_ok & ~commit_rd & (commit_addr == ADDR_W'(i + 1));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cfg_q[i] <= '0;
      else if (wr_en) cfg_q[i] <= commit_data;
    end
    assign cfg_o[i*DATA_W +: DATA_W] = cfg_q[i];
  end

  assign err_clr = commit_ok & commit_rd & (commit_addr == STATUS_ADDR);
  assign err_en  = commit_bad | err_clr;
  assign err_d   = commit_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err_q <= 1'b0;
    else if (err_en) err_q <= err_d;
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == STATUS_ADDR) rd_data = {stat_i, err_q};
    for (int i = 0; i < NUM_CFG; i++) begin
      if (rd_addr == ADDR_W'(i + 1)) rd_data = cfg_q[i];
    end
  end

  assign err_o = err_q;
endmodule

// File: rtl/spi_reg_target.sv
module spi_reg_target
  import spi_reg_pkg::*;
#(
  parameter int NUM_CFG     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      spi_cs_n,
  input  logic                      spi_sclk,
  input  logic                      spi_sdi,
  output logic                      spi_sdo,
  output logic                      spi_sdo_en,
  input  logic [DATA_W-2:0]         stat_i,
  output logic [NUM_CFG*DATA_W-1:0] cfg_o,
  output logic                      frame_err_o
);
  localparam int CNT_W = $clog2(FRAME_BITS + 2);

  logic [1:0]        rst_sync_q;
  logic              rst_n_s;
  logic              cs_n_s, sclk_s, sdi_s;
  logic              cs_fall, cs_rise, sclk_fall, sclk_rise;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data;
  logic              commit_ok, commit_bad, commit_rd;
  logic [ADDR_W-1:0] commit_addr;
  logic [DATA_W-1:0] commit_data;
  logic [CNT_W-1:0]  fall_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n_s),
    .cs_n_i(spi_cs_n), .sclk_i(spi_sclk), .sdi_i(spi_sdi),
    .cs_n_o(cs_n_s), .sclk_o(sclk_s), .sdi_o(sdi_s),
    .cs_fall_o(cs_fall), .cs_rise_o(cs_rise),
    .sclk_fall_o(sclk_fall), .sclk_rise_o(sclk_rise)
  );

  spi_frame_engine #(.CNT_W(CNT_W)) u_engine (
    .clk(clk), .rst_n(rst_n_s),
    .cs_n_s(cs_n_s), .sclk_s(sclk_s), .sdi_s(sdi_s),
    .cs_fall(cs_fall), .cs_rise(cs_rise),
    .sclk_fall(sclk_fall), .sclk_rise(sclk_rise),
    .err_flag_i(frame_err_o), .rd_data_i(rd_data),
    .rd_addr_o(rd_addr), .sdo_o(spi_sdo),
    .commit_ok_o(commit_ok), .commit_bad_o(commit_bad),
    .commit_rd_o(commit_rd), .commit_addr_o(commit_addr),
    .commit_data_o(commit_data), .fall_cnt_o(fall_cnt)
  );

  spi_reg_bank #(.NUM_CFG(NUM_CFG)) u_bank (
    .clk(clk), .rst_n(rst_n_s),
    .commit_ok(commit_ok), .commit_bad(commit_bad),
    .commit_rd(commit_rd), .commit_addr(commit_addr), .commit_data(commit_data),
    .rd_addr(rd_addr), .stat_i(stat_i),
    .rd_data(rd_data), .cfg_o(cfg_o), .err_o(frame_err_o)
  );

  assign spi_sdo_en = ~spi_cs_n;
endmodule

// File: rtl/spi_reg_target_chk.sv
module spi_reg_target_chk #(
  parameter int NUM_CFG = 8,
  parameter int CNT_W   = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cs_n_s,
  input logic                 spi_sdo,
  input logic [NUM_CFG*8-1:0] cfg_o,
  input logic                 frame_err_o,
  input logic                 commit_ok,
  input logic                 commit_bad,
  input logic [CNT_W-1:0]     fall_cnt
);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(17);

  p_sdo_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> !spi_sdo);

  p_cfg_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_ok |=> $stable(cfg_o));

  p_err_on_bad_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_bad |=> frame_err_o);

  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fall_cnt <= CNT_SAT);

  p_err_rise_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_err_o) |-> $past(commit_bad));

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_err_o && !commit_ok) |=> frame_err_o);

  p_cnt_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n_s && $past(cs_n_s)) |-> $stable(fall_cnt));
endmodule

bind spi_reg_target spi_reg_target_chk #(.NUM_CFG(NUM_CFG), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .cs_n_s(cs_n_s), .spi_sdo(spi_sdo),
  .cfg_o(cfg_o), .frame_err_o(frame_err_o), .commit_ok(commit_ok),
  .commit_bad(commit_bad), .fall_cnt(fall_cnt)
);

// File: tb/test_spi_reg_target.sv
`timescale 1ns/1ps
module test_spi_reg_target;
  localparam int NCFG = 8;
  localparam int HALF = 6;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            spi_cs_n = 1'b1, spi_sclk = 1'b0, spi_sdi = 1'b0;
  logic            spi_sdo, spi_sdo_en, frame_err_o;
  logic [6:0]      stat_i = 7'h00;
  logic [NCFG*8-1:0] cfg_o;

  int checks = 0;
  int fails  = 0;
  int en_miss = 0;
  logic [7:0] exp_cfg [NCFG];
  logic       exp_err = 1'b0;

  always #4 clk = ~clk;

  spi_reg_target #(.NUM_CFG(NCFG)) i_spi_reg_target (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
    .spi_sdi(spi_sdi), .spi_sdo(spi_sdo), .spi_sdo_en(spi_sdo_en),
    .stat_i(stat_i), .cfg_o(cfg_o), .frame_err_o(frame_err_o)
  );

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  function automatic logic [63:0] cfg_vec();
    logic [63:0] v = '0;
    for (int i = 0; i < NCFG; i++) v[i*8 +: 8] = exp_cfg[i];
    return v;
  endfunction

  function automatic logic [7:0] reg_val(input int a);
    if (a == 0) return {stat_i, exp_err};
    if (a <= NCFG) return exp_cfg[a-1];
    return 8'h00;
  endfunction

  task automatic xfer(input int nbits, input logic [31:0] word, input bit hi_start,
                      input bit hi_end, output logic [31:0] resp);
    resp = '0;
    spi_sclk = hi_start;
    wait_clks(HALF);
    spi_cs_n = 1'b0;
    wait_clks(HALF);
    for (int k = 0; k < nbits; k++) begin
      spi_sdi  = word[nbits-1-k];
      spi_sclk = 1'b1;
      wait_clks(HALF);
      if (!spi_sdo_en) en_miss++;
      resp = {resp[30:0], spi_sdo};
      spi_sclk = 1'b0;
      wait_clks(HALF);
    end
    if (hi_end) begin
      spi_sclk = 1'b1;
      wait_clks(HALF);
    end
    spi_cs_n = 1'b1;
    wait_clks(HALF);
    spi_sclk = 1'b0;
    spi_sdi  = 1'b0;
    wait_clks(2*HALF);
  endtask

  // valid 16-bit access with model update and response check
  task automatic access(input bit rd, input int a, input logic [7:0] d, input logic [2:0] rsvd,
                        input string req);
    logic [31:0] resp;
    logic [15:0] exp_resp;
    exp_resp = {exp_err, 7'h00, reg_val(a)};
    xfer(16, {16'h0, rd, 4'(a), rsvd, d}, 1'b0, 1'b0, resp);
    if (!rd && a >= 1 && a <= NCFG) exp_cfg[a-1] = d;
    if (rd && a == 0) exp_err = 1'b0;
    check({req, " R4 response"}, {48'h0, resp[15:0]}, {48'h0, exp_resp});
    check({req, " cfg_o"}, cfg_o, cfg_vec());
    check({req, " frame_err_o"}, {63'h0, frame_err_o}, {63'h0, exp_err});
  endtask

  initial begin
    wait_clks(150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] resp;
    for (int i = 0; i < NCFG; i++) exp_cfg[i] = 8'h00;
    wait_clks(4);
    rst_n = 1'b1;
    wait_clks(6);

    // R10 reset state
    check("R10 cfg_o", cfg_o, 64'h0);
    check("R10 frame_err_o", {63'h0, frame_err_o}, 64'h0);
    check("R10 spi_sdo", {63'h0, spi_sdo}, 64'h0);
    check("R1 sdo_en idle", {63'h0, spi_sdo_en}, 64'h0);

    // R3 R5 R2: write sweep over all addresses, reserved bits nonzero
    for (int a = 0; a < 16; a++)
      access(1'b0, a, 8'(a * 53 + 31), 3'(a + 5), "R3 R5 R2 write");
    // R4 R5: read sweep, write returns old value
    for (int a = 0; a < 16; a++)
      access(1'b1, a, 8'hFF, 3'b111, "R4 R5 read");
    for (int a = 1; a <= NCFG; a++)
      access(1'b0, a, 8'(a * 7 + 128), 3'b000, "R4 R3 overwrite");

    // R1: enable was high for every bit of every frame so far
    check("R1 sdo_en in frame", 64'(en_miss), 64'h0);
    check("R1 sdo_en after frame", {63'h0, spi_sdo_en}, 64'h0);
    check("R1 sdo low after frame", {63'h0, spi_sdo}, 64'h0);

    // R5: status register content for several status inputs
    for (int s = 0; s < 128; s += 37) begin
      stat_i = 7'(s);
      access(1'b1, 0, 8'h00, 3'b000, "R5 status");
    end

    // R6: every wrong frame length from 0 to 20 bits
    for (int n = 0; n <= 20; n++) begin
      logic [31:0] w;
      if (n == 16) continue;
      w = {16'h0, 1'b0, 4'd2, 3'b000, 8'h5A};
      w = (n < 16) ? (w >> (16 - n)) : (w << (n - 16));
      xfer(n, w, 1'b0, 1'b0, resp);
      exp_err = 1'b1;
      check("R6 bad length cfg_o", cfg_o, cfg_vec());
      check("R6 bad length flag", {63'h0, frame_err_o}, 64'h1);
      access(1'b1, 0, 8'h00, 3'b000, "R8 clear read");
    end

    // R7: serial clock high at select fall, and at select rise
    xfer(16, {16'h0, 1'b0, 4'd3, 3'b000, 8'hC3}, 1'b1, 1'b0, resp);
    exp_err = 1'b1;
    check("R7 high at start cfg_o", cfg_o, cfg_vec());
    check("R7 high at start flag", {63'h0, frame_err_o}, 64'h1);
    access(1'b1, 0, 8'h00, 3'b000, "R7 clear");
    xfer(16, {16'h0, 1'b0, 4'd4, 3'b000, 8'h3C}, 1'b0, 1'b1, resp);
    exp_err = 1'b1;
    check("R7 high at end cfg_o", cfg_o, cfg_vec());
    check("R7 high at end flag", {63'h0, frame_err_o}, 64'h1);

    // R8: flag survives a write to address 0 and a read elsewhere
    access(1'b0, 0, 8'h00, 3'b000, "R8 write status");
    access(1'b1, 3, 8'h00, 3'b000, "R8 read other");
    check("R8 still set", {63'h0, frame_err_o}, 64'h1);
    access(1'b1, 0, 8'h00, 3'b000, "R8 clear");
    check("R8 cleared", {63'h0, frame_err_o}, 64'h0);

    // R9: bus activity while deselected
    for (int k = 0; k < 40; k++) begin
      spi_sdi  = k[1];
      spi_sclk = ~spi_sclk;
      wait_clks(HALF);
    end
    spi_sclk = 1'b0;
    spi_sdi  = 1'b0;
    wait_clks(2*HALF);
    check("R9 idle cfg_o", cfg_o, cfg_vec());
    check("R9 idle flag", {63'h0, frame_err_o}, 64'h0);
    check("R9 idle sdo", {63'h0, spi_sdo}, 64'h0);
    check("R9 idle sdo_en", {63'h0, spi_sdo_en}, 64'h0);
    access(1'b1, 5, 8'h00, 3'b000, "R9 read after idle");

    summary();
    $finish;
  end
endmodule